// File: doc/BRIEF.md
# Flag Offset Register Readback Sequencer

This block returns the two programmable flag thresholds of a FIFO, the almost-empty offset and the almost-full offset, over the FIFO's own output data bus. The offsets can be wider than the bus, so each one is cut into lane-wide chunks. Each enabled readback cycle places one chunk on the bus. The sequence runs through every chunk of the almost-empty offset, lowest chunk first. It then runs through the almost-full offset the same way and wraps back to the start.

The output register is shared with ordinary FIFO reads. A plain read (read enable low, load enable high) loads the FIFO word. A readback (both enables low) replaces whatever word the register held. The sequence can be paused at any chunk by lifting either enable. Ordinary traffic may run during the pause, and the next readback continues where the sequence stopped.

The bus width select picks a full, half or quarter lane. The number of reads per offset follows from that lane width. Readback works the same way whether the surrounding FIFO runs in standard or first-word-fall-through timing. The block has no valid/ready stream edge: it follows the FIFO's plain strobe interface.

Top module: `flag_offset_readback`

## Requirements
- R1: After reset `q` is all zeros, and the first readback returns chunk 0 of the almost-empty offset.
- R2: The chunk position advances only on a rising `clk` edge with `rd_en_n` = 0 and `ld_en_n` = 0. Any other combination leaves the position unchanged.
- R3: After the last chunk of the almost-empty offset, the next readback returns chunk 0 of the almost-full offset. After the last chunk of the almost-full offset, the next readback returns chunk 0 of the almost-empty offset.
- R4: Chunk k of an offset holds offset bits [k*L+L-1 : k*L], where L is the lane width. Chunks are returned in rising k.
- R5: `lane_sel` 2'b00 selects lane width L = BUS_W, 2'b01 selects BUS_W/2, and 2'b10 or 2'b11 select BUS_W/4. The chunk count per offset is ceil(OFS_W / L).
- R6: A pause of any length, with ordinary reads between readbacks, resumes at the chunk after the last one returned.
- R7: With `rd_en_n` = 0 and `ld_en_n` = 1, `q` takes `fifo_word` on the edge. A readback replaces the word held on `q`.
- R8: Offset bits beyond OFS_W in the final chunk, and all `q` bits at or above L, read as zero.
- R9: With `rd_en_n` = 1, `q` keeps its value whatever `ld_en_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en_n | input | 1 | Read enable, active low |
| ld_en_n | input | 1 | Offset access enable, active low |
| lane_sel | input | 2 | Output lane width select |
| empty_ofs | input | OFS_W | Almost-empty threshold value |
| full_ofs | input | OFS_W | Almost-full threshold value |
| fifo_word | input | BUS_W | Word from FIFO storage for ordinary reads |
| q | output | BUS_W | Shared output data register |

## Verification
Back-to-back readbacks are run in every lane mode. They separate lowest-first chunk order from a reversed order, and a correct wrap point from one chunk too early or too late. Offset values whose top chunk is partial expose missing zero fill. Pauses are driven with each enable lifted alone, with both lifted, and with ordinary reads between them. These tell a held chunk position from one that creeps forward, and a held output from one that is overwritten. A long random stretch mixes all four enable combinations against a behavioural model, checked every cycle.

// File: rtl/ofs_rb_pkg.sv
package ofs_rb_pkg;
  typedef enum logic [1:0] {
    LANE_FULL    = 2'b00,
    LANE_HALF    = 2'b01,
    LANE_QUARTER = 2'b10
  } lane_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Shift amount applied to BUS_W for a given select code.
  function automatic int lane_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/ofs_rb_pointer.sv
module ofs_rb_pointer #(
  parameter int OFS_W = 20,
  parameter int BUS_W = 16,
  localparam int CNT_F = ofs_rb_pkg::ceil_div(OFS_W, BUS_W),
  localparam int CNT_H = ofs_rb_pkg::ceil_div(OFS_W, BUS_W / 2),
  localparam int CNT_Q = ofs_rb_pkg::ceil_div(OFS_W, BUS_W / 4),
  localparam int IDX_W = (CNT_Q > 1) ? $clog2(CNT_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [1:0]       lane_sel,
  output logic             sel_full,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] last_idx;

  always_comb begin
    case (ofs_rb_pkg::lane_shift(lane_sel))
      0:       last_idx = IDX_W'(CNT_F - 1);
      1:       last_idx = IDX_W'(CNT_H - 1);
      default: last_idx = IDX_W'(CNT_Q - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_full <= 1'b0;
      idx      <= '0;
    end else if (step) begin
      if (idx >= last_idx) begin
        idx      <= '0;
        sel_full <= ~sel_full;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ofs_rb_slicer.sv
module ofs_rb_slicer #(
  parameter int OFS_W = 20,
  parameter int BUS_W = 16,
  parameter int IDX_W = 3
) (
  input  logic [OFS_W-1:0] empty_ofs,
  input  logic [OFS_W-1:0] full_ofs,
  input  logic             sel_full,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       lane_sel,
  output logic [BUS_W-1:0] chunk
);
  logic [OFS_W-1:0] src;
  logic [BUS_W-1:0] lane_out [3];

  assign src = sel_full ? full_ofs : empty_ofs;

  for (genvar m = 0; m < 3; m++) begin : g_lane
    localparam int LW   = BUS_W >> m;
    localparam int CNT  = ofs_rb_pkg::ceil_div(OFS_W, LW);
    localparam int PADW = CNT * LW;
    logic [PADW-1:0] padded;
    logic [LW-1:0]   pick;

    assign padded = PADW'(src);

    always_comb begin
      pick = '0;
      for (int k = 0; k < CNT; k++) begin
        if (int'(idx) == k) pick = padded[k*LW +: LW];
      end
    end

    assign lane_out[m] = BUS_W'(pick);
  end

  always_comb begin
    case (ofs_rb_pkg::lane_shift(lane_sel))
      0:       chunk = lane_out[0];
      1:       chunk = lane_out[1];
      default: chunk = lane_out[2];
    endcase
  end
endmodule

// File: rtl/ofs_rb_outreg.sv
module ofs_rb_outreg #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_chunk,
  input  logic             take_word,
  input  logic [BUS_W-1:0] chunk,
  input  logic [BUS_W-1:0] word,
  output logic [BUS_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (take_chunk) q <= chunk;
    else if (take_word)  q <= word;
  end
endmodule

// File: rtl/flag_offset_readback.sv
module flag_offset_readback #(
  parameter int OFS_W = 20,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_n,
  input  logic             ld_en_n,
  input  logic [1:0]       lane_sel,
  input  logic [OFS_W-1:0] empty_ofs,
  input  logic [OFS_W-1:0] full_ofs,
  input  logic [BUS_W-1:0] fifo_word,
  output logic [BUS_W-1:0] q
);
  localparam int CNT_Q = ofs_rb_pkg::ceil_div(OFS_W, BUS_W / 4);
  localparam int IDX_W = (CNT_Q > 1) ? $clog2(CNT_Q) : 1;

  logic             rb_step;
  logic             word_rd;
  logic             ptr_sel_full;
  logic [IDX_W-1:0] ptr_idx;
  logic [BUS_W-1:0] cur_chunk;

  assign rb_step = ~rd_en_n & ~ld_en_n;
  assign word_rd = ~rd_en_n &  ld_en_n;

  ofs_rb_pointer #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(rb_step), .lane_sel(lane_sel),
    .sel_full(ptr_sel_full), .idx(ptr_idx)
  );

  ofs_rb_slicer #(.OFS_W(OFS_W), .BUS_W(BUS_W), .IDX_W(IDX_W)) u_slice (
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .sel_full(ptr_sel_full),
    .idx(ptr_idx), .lane_sel(lane_sel), .chunk(cur_chunk)
  );

  ofs_rb_outreg #(.BUS_W(BUS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take_chunk(rb_step), .take_word(word_rd),
    .chunk(cur_chunk), .word(fifo_word), .q(q)
  );
endmodule

// File: rtl/ofs_rb_checks.sv
module ofs_rb_checks #(
  parameter int OFS_W = 20,
  parameter int BUS_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en_n,
  input logic             ld_en_n,
  input logic [1:0]       lane_sel,
  input logic [BUS_W-1:0] fifo_word,
  input logic [BUS_W-1:0] q,
  input logic             sel_full,
  input logic [IDX_W-1:0] idx
);
  localparam int CNT_F = ofs_rb_pkg::ceil_div(OFS_W, BUS_W);
  localparam int CNT_H = ofs_rb_pkg::ceil_div(OFS_W, BUS_W / 2);
  localparam int CNT_Q = ofs_rb_pkg::ceil_div(OFS_W, BUS_W / 4);

  logic [IDX_W-1:0] chk_last;
  always_comb begin
    case (lane_sel)
      2'b00:   chk_last = IDX_W'(CNT_F - 1);
      2'b01:   chk_last = IDX_W'(CNT_H - 1);
      default: chk_last = IDX_W'(CNT_Q - 1);
    endcase
  end

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_n || ld_en_n) |=> ($stable(idx) && $stable(sel_full)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && !ld_en_n && idx == chk_last) |=> (idx == '0 && sel_full != $past(sel_full)));

  assert_word_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && ld_en_n) |=> (q == $past(fifo_word)));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && !ld_en_n && lane_sel == 2'b01) |=> ((q >> (BUS_W / 2)) == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> $stable(q));
endmodule

bind flag_offset_readback ofs_rb_checks #(.OFS_W(OFS_W), .BUS_W(BUS_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .ld_en_n(ld_en_n),
  .lane_sel(lane_sel), .fifo_word(fifo_word), .q(q),
  .sel_full(ptr_sel_full), .idx(ptr_idx)
);

// File: tb/flag_offset_readback_tb.sv
module flag_offset_readback_tb;
  localparam int OFS_W = 20;
  localparam int BUS_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_en_n = 1'b1;
  logic             ld_en_n = 1'b1;
  logic [1:0]       lane_sel = 2'b00;
  logic [OFS_W-1:0] empty_ofs = '0;
  logic [OFS_W-1:0] full_ofs = '0;
  logic [BUS_W-1:0] fifo_word = '0;
  logic [BUS_W-1:0] q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int               m_reg = 0;
  int               m_idx = 0;
  logic [BUS_W-1:0] m_q = '0;

  always #4 clk = ~clk;

  flag_offset_readback #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .ld_en_n(ld_en_n),
    .lane_sel(lane_sel), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .fifo_word(fifo_word), .q(q)
  );

  function automatic int lw_of(input logic [1:0] s);
    return (s == 2'b00) ? BUS_W : (s == 2'b01) ? BUS_W / 2 : BUS_W / 4;
  endfunction

  function automatic logic [BUS_W-1:0] m_chunk(input logic [OFS_W-1:0] v, input int k,
                                               input logic [1:0] s);
    logic [63:0] t;
    int w;
    w = lw_of(s);
    t = 64'(v) >> (k * w);
    t = t & ((64'd1 << w) - 64'd1);
    return t[BUS_W-1:0];
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (q !== m_q) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h", tag, q, m_q);
    end
  endtask

  // Drive one cycle at a falling edge, advance the model, compare at the next falling edge.
  task automatic cycle(input logic r, input logic l, input string tag);
    rd_en_n   = r;
    ld_en_n   = l;
    fifo_word = BUS_W'($urandom);
    if (!r && !l) begin
      m_q = m_chunk((m_reg == 0) ? empty_ofs : full_ofs, m_idx, lane_sel);
      m_idx++;
      if (m_idx == (OFS_W + lw_of(lane_sel) - 1) / lw_of(lane_sel)) begin
        m_idx = 0;
        m_reg = 1 - m_reg;
      end
    end else if (!r) begin
      m_q = fifo_word;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0; rd_en_n = 1'b1; ld_en_n = 1'b1; lane_sel = s;
    m_reg = 0; m_idx = 0; m_q = '0;
    @(negedge clk);
    compare("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    empty_ofs = 20'hA5C3B;
    full_ofs  = 20'h6E917;

    // full lane: 2 chunks each, top chunk is 4 bits wide (R8 zero fill)
    do_reset(2'b00);
    cycle(0, 0, "R1 first chunk empty LSB");
    cycle(0, 0, "R8 partial top chunk");
    cycle(0, 0, "R3 full offset after empty");
    cycle(0, 0, "R4 full offset high chunk");
    cycle(0, 0, "R3 wrap to empty LSB");

    // half lane: 3 chunks each
    do_reset(2'b01);
    for (int i = 0; i < 7; i++) cycle(0, 0, "R5 half lane sequence");

    // pause forms, then resume
    cycle(1, 0, "R2 ld low only, no step");
    cycle(1, 1, "R9 idle hold");
    cycle(0, 1, "R7 ordinary read loads word");
    cycle(1, 0, "R9 hold after word");
    cycle(0, 0, "R7 readback replaces word");
    cycle(0, 1, "R6 word during pause");
    cycle(0, 1, "R6 second word");
    cycle(0, 0, "R6 resume position");

    // quarter lane, both codes
    do_reset(2'b10);
    for (int i = 0; i < 11; i++) cycle(0, 0, "R5 quarter lane code 10");
    do_reset(2'b11);
    for (int i = 0; i < 11; i++) cycle(0, 0, "R5 quarter lane code 11");

    // random mixing in each mode
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      empty_ofs = OFS_W'($urandom);
      full_ofs  = OFS_W'($urandom);
      for (int i = 0; i < 600; i++) begin
        logic r;
        logic l;
        r = 1'($urandom);
        l = 1'($urandom);
        if (!r && !l)  cycle(r, l, "R4 random readback");
        else if (!r)   cycle(r, l, "R6 random ordinary read");
        else if (!l)   cycle(r, l, "R2 random no step");
        else           cycle(r, l, "R9 random idle");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule